// File: doc/BRIEF.md
# Single-Wire Debug Frame Sequencer

This block is the host end of a one-wire debug link. A local requester hands it a frame kind, an 8-bit command, a 16-bit address and 16-bit write data. The sequencer turns these into a frame of bit slots on an open-drain line. The line is pulled low only through `wire_oe_o`, and the level the target leaves on it comes back on `wire_i`. The field order and a fixed idle pause depend on the frame kind. In the receive slots the sequencer collects a 16-bit word that the target drives back.

A target clock is a run-time number of bus clocks (`div_i`). Every bit slot lasts 16 target clocks. The host opens each slot with a falling edge and holds the line low for a time that encodes the bit. While a frame and its trailing pause are in progress, `busy_o` is high and new requests are ignored. A one-cycle `done_o` pulse marks the end of the frame and presents any received word.

Top module: `dwh_host`

## Requirements
- R1: After reset and whenever no frame is in progress, `wire_oe_o` is 0 (line released), `busy_o` is 0 and `done_o` is 0. `rd_data_o` resets to 0.
- R2: A bit slot lasts 16 × D bus cycles and starts with a rising edge of `wire_oe_o`, where D is the divider. The slots of one field follow each other with no idle time, so their falling edges are 16 × D cycles apart.
- R3: A transmitted 1 pulls the line low for 4 target clocks, and a transmitted 0 pulls it low for 13. Every field is sent most significant bit first.
- R4: In a receive slot the host pulls low for 2 target clocks only. It samples the synchronized line 10 target clocks after the slot starts, and reads high as 1. Sixteen such bits are collected MSB first and are presented on `rd_data_o` in the `done_o` cycle. `rd_data_o` changes only then.
- R5: Kind 0 (direct read) sends the command and the address. The line then stays idle 150 bus cycles, and 16 receive slots follow.
- R6: Kind 1 (direct write) sends the command, the address and the data. A trailing idle time of 150 bus cycles follows.
- R7: Kind 2 (routine read) sends the command. The line then stays idle 48 bus cycles, and 16 receive slots follow.
- R8: Kind 3 (routine write) sends the command and the data. A trailing idle time of 36 bus cycles follows.
- R9: Kind 4 (resume/step) sends the command. A trailing hold-off of 76 bus cycles follows.
- R10: Kinds 5 to 7 send the command alone, with no pause.
- R11: A request is accepted when `req_valid_i` is high while `busy_o` is low. `busy_o` is high from the next cycle until the frame ends, and requests made meanwhile are ignored. `done_o` is a one-cycle pulse in the first cycle `busy_o` is low again. It comes 16 × D + G − 1 cycles after the last slot's falling edge, where G is the trailing pause (0 if none). Between fields, falling edges are 16 × D + G apart, where G is the pause between them.
- R12: `div_i` is captured at acceptance, and a value of 0 acts as 1. Later changes to `div_i` have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 8 | Bus clocks per target clock |
| req_valid_i | input | 1 | Frame request |
| req_kind_i | input | 3 | Frame kind code (0 to 7) |
| req_op_i | input | 8 | Command byte |
| req_addr_i | input | 16 | Address field |
| req_data_i | input | 16 | Write data field |
| busy_o | output | 1 | Frame or trailing pause in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rd_data_o | output | 16 | Received word |
| wire_i | input | 1 | Level sensed on the serial line |
| wire_oe_o | output | 1 | 1 pulls the serial line low |

## Verification
The properties assume that the target pulls the line low only inside a receive slot, and never beyond 13 target clocks of that slot. They also assume that `wire_i` reads high at every other time. The bench's target model starts its low pulse when it sees the host's falling edge, and only in the slots that the frame kind makes receive slots. It holds the pulse for exactly 13 × D cycles for a 0 bit and never drives for a 1. Requests are raised only in idle cycles, except in the deliberate test where requests arrive while busy. The divider is changed in the middle of a frame only to show that it has no effect.

// File: rtl/dwh_pkg.sv
package dwh_pkg;

  // frame kind codes
  localparam logic [2:0] KIND_HW_RD  = 3'd0;
  localparam logic [2:0] KIND_HW_WR  = 3'd1;
  localparam logic [2:0] KIND_FW_RD  = 3'd2;
  localparam logic [2:0] KIND_FW_WR  = 3'd3;
  localparam logic [2:0] KIND_RESUME = 3'd4;

  // one step of a frame program
  typedef enum logic [2:0] {
    PH_OP, PH_ADDR, PH_DATA, PH_RX, PH_GAP, PH_END
  } phase_e;

  // Step idx of the program for frame kind k.
  function automatic phase_e phase_at(input logic [2:0] k, input logic [2:0] idx);
    phase_e p;
    p = PH_END;
    case (k)
      KIND_HW_RD:
        case (idx)
          3'd0: p = PH_OP;
          3'd1: p = PH_ADDR;
          3'd2: p = PH_GAP;
          3'd3: p = PH_RX;
          default: p = PH_END;
        endcase
      KIND_HW_WR:
        case (idx)
          3'd0: p = PH_OP;
          3'd1: p = PH_ADDR;
          3'd2: p = PH_DATA;
          3'd3: p = PH_GAP;
          default: p = PH_END;
        endcase
      KIND_FW_RD:
        case (idx)
          3'd0: p = PH_OP;
          3'd1: p = PH_GAP;
          3'd2: p = PH_RX;
          default: p = PH_END;
        endcase
      KIND_FW_WR:
        case (idx)
          3'd0: p = PH_OP;
          3'd1: p = PH_DATA;
          3'd2: p = PH_GAP;
          default: p = PH_END;
        endcase
      KIND_RESUME:
        case (idx)
          3'd0: p = PH_OP;
          3'd1: p = PH_GAP;
          default: p = PH_END;
        endcase
      default:
        p = (idx == 3'd0) ? PH_OP : PH_END;
    endcase
    return p;
  endfunction

  function automatic logic is_slot_phase(input phase_e p);
    return (p == PH_OP) || (p == PH_ADDR) || (p == PH_DATA) || (p == PH_RX);
  endfunction

endpackage

// File: rtl/dwh_tick.sv
module dwh_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == div - 1'b1);
  assign tick   = en && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dwh_slot.sv
module dwh_slot #(
  parameter int DIV_W     = 8,
  parameter int SLOT_TC   = 16,
  parameter int ONE_TC    = 4,
  parameter int ZERO_TC   = 13,
  parameter int STROBE_TC = 2,
  parameter int SAMPLE_TC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_rx,
  input  logic             start_bit,
  input  logic [DIV_W-1:0] div,
  input  logic             line_s,
  output logic             drive_low,
  output logic             last,
  output logic             rx_bit
);
  localparam int TC_W = $clog2(SLOT_TC);
  localparam logic [TC_W:0]   LEN_ONE  = (TC_W+1)'(ONE_TC);
  localparam logic [TC_W:0]   LEN_ZERO = (TC_W+1)'(ZERO_TC);
  localparam logic [TC_W:0]   LEN_STB  = (TC_W+1)'(STROBE_TC);
  localparam logic [TC_W-1:0] TC_LAST  = TC_W'(SLOT_TC - 1);
  localparam logic [TC_W-1:0] TC_SMP   = TC_W'(SAMPLE_TC - 1);

  logic            active_q, rx_mode_q, bit_q, rx_q, tick;
  logic [TC_W-1:0] tc_q;
  logic [TC_W:0]   low_len;

  dwh_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .en   (active_q),
    .div  (div),
    .tick (tick)
  );

  always_comb begin
    if (rx_mode_q)  low_len = LEN_STB;
    else if (bit_q) low_len = LEN_ONE;
    else            low_len = LEN_ZERO;
  end

  assign last      = active_q && tick && (tc_q == TC_LAST);
  assign drive_low = active_q && ({1'b0, tc_q} < low_len);
  assign rx_bit    = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      rx_mode_q <= 1'b0;
      bit_q     <= 1'b0;
      tc_q      <= '0;
      rx_q      <= 1'b0;
    end else begin
      if (start) begin
        active_q  <= 1'b1;
        rx_mode_q <= start_rx;
        bit_q     <= start_bit;
        tc_q      <= '0;
      end else if (active_q && tick) begin
        if (tc_q == TC_LAST) begin
          active_q <= 1'b0;
          tc_q     <= '0;
        end else begin
          tc_q <= tc_q + 1'b1;
        end
      end
      // sample at the end of the target clock before SAMPLE_TC
      if (active_q && rx_mode_q && tick && (tc_q == TC_SMP)) begin
        rx_q <= line_s;
      end
    end
  end
endmodule

// File: rtl/dwh_seq.sv
module dwh_seq
  import dwh_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int OP_W       = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int HW_GAP     = 150,
  parameter int FW_RD_GAP  = 48,
  parameter int FW_WR_GAP  = 36,
  parameter int RESUME_GAP = 76
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DIV_W-1:0]  req_div,
  input  logic              slot_last,
  input  logic              slot_rx_bit,
  output logic              slot_start,
  output logic              slot_start_rx,
  output logic              slot_start_bit,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FLD_W  = (OP_W > ADDR_W) ? ((OP_W > DATA_W) ? OP_W : DATA_W)
                                          : ((ADDR_W > DATA_W) ? ADDR_W : DATA_W);
  localparam int GAP_A  = (HW_GAP > FW_RD_GAP) ? HW_GAP : FW_RD_GAP;
  localparam int GAP_B  = (FW_WR_GAP > RESUME_GAP) ? FW_WR_GAP : RESUME_GAP;
  localparam int MAXGAP = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int GAP_W  = $clog2(MAXGAP + 1);
  localparam int CNT_W  = $clog2(FLD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_GAP} state_e;

  state_e            state_q;
  phase_e            ph_q, nxt_ph;
  logic [2:0]        kind_q, kind_sel, idx_q, nxt_idx;
  logic [OP_W-1:0]   op_q, op_src;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rx_q, rx_next;
  logic [FLD_W-1:0]  sh_q, load_val;
  logic [CNT_W-1:0]  left_q, load_len;
  logic [GAP_W-1:0]  gap_q, gap_len;
  logic              accept, slot_end, more, advance;

  assign accept   = (state_q == S_IDLE) && req_valid;
  assign kind_sel = (state_q == S_IDLE) ? req_kind : kind_q;
  assign op_src   = (state_q == S_IDLE) ? req_op : op_q;
  assign nxt_idx  = (state_q == S_IDLE) ? 3'd0 : idx_q + 3'd1;
  assign nxt_ph   = phase_at(kind_sel, nxt_idx);
  assign slot_end = (state_q == S_SLOT) && slot_last;
  assign more     = slot_end && (left_q != '0);
  assign advance  = accept || (slot_end && (left_q == '0)) ||
                    ((state_q == S_GAP) && (gap_q == '0));
  assign rx_next  = {rx_q[DATA_W-2:0], slot_rx_bit};

  always_comb begin
    load_val = '0;
    load_len = CNT_W'(DATA_W - 1);
    case (nxt_ph)
      PH_OP: begin
        load_val = FLD_W'(op_src) << (FLD_W - OP_W);
        load_len = CNT_W'(OP_W - 1);
      end
      PH_ADDR: begin
        load_val = FLD_W'(addr_q) << (FLD_W - ADDR_W);
        load_len = CNT_W'(ADDR_W - 1);
      end
      PH_DATA: begin
        load_val = FLD_W'(data_q) << (FLD_W - DATA_W);
        load_len = CNT_W'(DATA_W - 1);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (kind_q)
      KIND_HW_RD, KIND_HW_WR: gap_len = GAP_W'(HW_GAP - 1);
      KIND_FW_RD:             gap_len = GAP_W'(FW_RD_GAP - 1);
      KIND_FW_WR:             gap_len = GAP_W'(FW_WR_GAP - 1);
      KIND_RESUME:            gap_len = GAP_W'(RESUME_GAP - 1);
      default:                gap_len = '0;
    endcase
  end

  assign slot_start     = more || (advance && is_slot_phase(nxt_ph));
  assign slot_start_rx  = more ? (ph_q == PH_RX) : (nxt_ph == PH_RX);
  assign slot_start_bit = more ? sh_q[FLD_W-2] : load_val[FLD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ph_q    <= PH_END;
      kind_q  <= '0;
      idx_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      div_q   <= DIV_W'(1);
      sh_q    <= '0;
      left_q  <= '0;
      gap_q   <= '0;
      rx_q    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        kind_q <= req_kind;
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        div_q  <= (req_div == '0) ? DIV_W'(1) : req_div;
      end
      if (slot_end && (ph_q == PH_RX)) begin
        rx_q <= rx_next;
      end
      if (more) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end else if (advance) begin
        idx_q <= nxt_idx;
        ph_q  <= nxt_ph;
        if (is_slot_phase(nxt_ph)) begin
          sh_q    <= load_val;
          left_q  <= load_len;
          state_q <= S_SLOT;
        end else if (nxt_ph == PH_GAP) begin
          gap_q   <= gap_len;
          state_q <= S_GAP;
        end else begin
          state_q <= S_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          if (slot_end && (ph_q == PH_RX)) begin
            rd_data <= rx_next;
          end
        end
      end else if (state_q == S_GAP) begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwh_host.sv
module dwh_host #(
  parameter int DIV_W      = 8,
  parameter int OP_W       = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SLOT_TC    = 16,
  parameter int ONE_TC     = 4,
  parameter int ZERO_TC    = 13,
  parameter int STROBE_TC  = 2,
  parameter int SAMPLE_TC  = 10,
  parameter int HW_GAP     = 150,
  parameter int FW_RD_GAP  = 48,
  parameter int FW_WR_GAP  = 36,
  parameter int RESUME_GAP = 76,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wire_i,
  output logic              wire_oe_o
);
  logic             line_s, s_start, s_rx, s_bit, s_last, s_rxbit, s_drive;
  logic [DIV_W-1:0] div_q;

  generate
    if (SYNC_N == 0) begin : g_nosync
      assign line_s = wire_i;
    end else begin : g_sync
      logic [SYNC_N-1:0] sq;
      always_ff @(posedge clk) begin
        if (rst) begin
          sq <= '1;
        end else begin
          sq[0] <= wire_i;
          for (int i = 1; i < SYNC_N; i++) sq[i] <= sq[i-1];
        end
      end
      assign line_s = sq[SYNC_N-1];
    end
  endgenerate

  dwh_seq #(
    .DIV_W(DIV_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HW_GAP(HW_GAP), .FW_RD_GAP(FW_RD_GAP), .FW_WR_GAP(FW_WR_GAP),
    .RESUME_GAP(RESUME_GAP)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid_i),
    .req_kind       (req_kind_i),
    .req_op         (req_op_i),
    .req_addr       (req_addr_i),
    .req_data       (req_data_i),
    .req_div        (div_i),
    .slot_last      (s_last),
    .slot_rx_bit    (s_rxbit),
    .slot_start     (s_start),
    .slot_start_rx  (s_rx),
    .slot_start_bit (s_bit),
    .div_q          (div_q),
    .busy           (busy_o),
    .done           (done_o),
    .rd_data        (rd_data_o)
  );

  dwh_slot #(
    .DIV_W(DIV_W), .SLOT_TC(SLOT_TC), .ONE_TC(ONE_TC), .ZERO_TC(ZERO_TC),
    .STROBE_TC(STROBE_TC), .SAMPLE_TC(SAMPLE_TC)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .start     (s_start),
    .start_rx  (s_rx),
    .start_bit (s_bit),
    .div       (div_q),
    .line_s    (line_s),
    .drive_low (s_drive),
    .last      (s_last),
    .rx_bit    (s_rxbit)
  );

  always_ff @(posedge clk) begin
    if (rst) wire_oe_o <= 1'b0;
    else     wire_oe_o <= s_drive;
  end
endmodule

// File: rtl/dwh_host_chk.sv
module dwh_host_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wire_oe_o
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !wire_oe_o);

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !busy_o) |=> busy_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(rd_data_o));
endmodule

bind dwh_host dwh_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_data_o   (rd_data_o),
  .wire_oe_o   (wire_oe_o)
);

// File: tb/tb_dwh_host.sv
module tb_dwh_host;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_i = 8'd1;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_kind_i = '0;
  logic [7:0]  req_op_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_data_i = '0;
  logic        busy_o, done_o, wire_oe_o, wire_i;
  logic [15:0] rd_data_o;
  logic        tgt_low = 1'b0;

  always #4 clk = ~clk;

  assign wire_i = !(wire_oe_o || tgt_low);

  dwh_host dut (
    .clk(clk), .rst(rst), .div_i(div_i), .req_valid_i(req_valid_i),
    .req_kind_i(req_kind_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
    .req_data_i(req_data_i), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .wire_i(wire_i), .wire_oe_o(wire_oe_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // line monitor and target model
  int cyc = 0;
  int n_edges = 0;
  int edge_t [64];
  int len_t  [64];
  int cur_len = 0;
  logic prev_oe = 1'b0;
  int done_seen = 0;
  int done_t = 0;
  logic [15:0] rd_cap = '0;
  int tgt_ntx = 999;
  int tgt_div = 1;
  logic [15:0] tgt_word = '0;
  int tgt_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (wire_oe_o && !prev_oe) begin
      if (n_edges >= tgt_ntx && n_edges < tgt_ntx + 16) begin
        if (!tgt_word[15 - (n_edges - tgt_ntx)]) tgt_cnt = 13 * tgt_div;
      end
      if (n_edges < 64) edge_t[n_edges] = cyc;
      n_edges++;
      cur_len = 1;
    end else if (wire_oe_o) begin
      cur_len++;
    end else if (prev_oe && n_edges >= 1 && n_edges <= 64) begin
      len_t[n_edges-1] = cur_len;
    end
    prev_oe = wire_oe_o;
    if (tgt_cnt > 0) begin
      tgt_low = 1'b1;
      tgt_cnt--;
    end else begin
      tgt_low = 1'b0;
    end
    if (done_o) begin
      done_seen++;
      done_t = cyc;
      rd_cap = rd_data_o;
    end
  end

  // expected slot pattern, worked out from the requirements
  int exp_len [64];
  int exp_gap [64];
  int exp_n = 0;
  int exp_end = 0;

  task automatic push(input int l, input int g);
    exp_len[exp_n] = l;
    exp_gap[exp_n] = g;
    exp_n++;
  endtask

  task automatic push_word(input logic [15:0] w, input int nb, input int g);
    for (int i = nb - 1; i >= 0; i--) push(w[i] ? 4 : 13, (i == nb - 1) ? g : 0);
  endtask

  task automatic push_rx(input int g);
    for (int i = 0; i < 16; i++) push(2, (i == 0) ? g : 0);
  endtask

  task automatic build(input logic [2:0] k, input logic [7:0] op,
                       input logic [15:0] addr, input logic [15:0] data);
    exp_n = 0;
    exp_end = 0;
    push_word({8'h00, op}, 8, 0);
    case (k)
      3'd0: begin push_word(addr, 16, 0); push_rx(150); end
      3'd1: begin push_word(addr, 16, 0); push_word(data, 16, 0); exp_end = 150; end
      3'd2: push_rx(48);
      3'd3: begin push_word(data, 16, 0); exp_end = 36; end
      3'd4: exp_end = 76;
      default: ;
    endcase
  endtask

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] k, input logic [7:0] d, input logic [7:0] op,
                       input logic [15:0] addr, input logic [15:0] data,
                       input logic [15:0] rxw);
    wait_idle();
    n_edges = 0;
    done_seen = 0;
    tgt_word = rxw;
    tgt_div = (d == 0) ? 1 : int'(d);
    tgt_ntx = (k == 3'd0) ? 24 : (k == 3'd2) ? 8 : 999;
    div_i = d;
    req_kind_i = k;
    req_op_i = op;
    req_addr_i = addr;
    req_data_i = data;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 8000; t++) begin
      if (done_seen != 0) break;
      @(negedge clk);
    end
  endtask

  task automatic verify(input logic [2:0] k, input int de, input logic [15:0] rxw,
                        input bit chg);
    int bad_len, bad_sp, last;
    string rq;
    rq = kind_tag(k);
    bad_len = 0;
    bad_sp = 0;
    check(done_seen == 1, "R11", "done pulses", done_seen, 1);
    check(n_edges == exp_n, {rq, " R2"}, "slot count", n_edges, exp_n);
    for (int i = 0; i < exp_n && i < n_edges && i < 64; i++) begin
      if (len_t[i] != exp_len[i] * de) bad_len++;
      if (i > 0 && (edge_t[i] - edge_t[i-1]) != 16 * de + exp_gap[i]) bad_sp++;
    end
    check(bad_len == 0, "R3/R4", "low-time mismatches", bad_len, 0);
    check(bad_sp == 0, {rq, " R2"}, "edge spacing mismatches", bad_sp, 0);
    last = (n_edges >= 1 && n_edges <= 64) ? edge_t[n_edges-1] : 0;
    check(done_t - last == 16 * de + exp_end - 1, {rq, " R11"}, "done delay",
          done_t - last, 16 * de + exp_end - 1);
    if (k == 3'd0 || k == 3'd2)
      check(rd_cap == rxw, "R4", "read word", int'(rd_cap), int'(rxw));
    if (chg) check(bad_len == 0 && bad_sp == 0, "R12", "divider held", bad_len + bad_sp, 0);
  endtask

  // kind, divider, command, address, data, word returned by the target
  localparam logic [66:0] VEC [0:8] = '{
    {3'd0, 8'd1, 8'hA5, 16'h1234, 16'h0000, 16'hBEEF},
    {3'd1, 8'd2, 8'h3C, 16'hFFFF, 16'h0001, 16'h0000},
    {3'd2, 8'd1, 8'h81, 16'h0000, 16'h0000, 16'h8001},
    {3'd3, 8'd3, 8'h7E, 16'h0000, 16'hA55A, 16'h0000},
    {3'd4, 8'd1, 8'h08, 16'h0000, 16'h0000, 16'h0000},
    {3'd5, 8'd2, 8'hFF, 16'h0000, 16'h0000, 16'h0000},
    {3'd0, 8'd3, 8'h00, 16'h0000, 16'h0000, 16'hFFFF},
    {3'd2, 8'd0, 8'h96, 16'h0000, 16'h0000, 16'h0000},
    {3'd7, 8'd1, 8'h01, 16'h0000, 16'h0000, 16'h5A5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset
    check(!busy_o, "R1", "busy after reset", int'(busy_o), 0);
    check(!done_o, "R1", "done after reset", int'(done_o), 0);
    check(!wire_oe_o, "R1", "line released after reset", int'(wire_oe_o), 0);
    check(rd_data_o == 16'h0, "R1", "read word after reset", int'(rd_data_o), 0);

    for (int v = 0; v < 9; v++) begin
      logic [66:0] e;
      int de;
      e = VEC[v];
      de = (e[63:56] == 8'd0) ? 1 : int'(e[63:56]);
      issue(e[66:64], e[63:56], e[55:48], e[47:32], e[31:16], e[15:0]);
      wait_done();
      build(e[66:64], e[55:48], e[47:32], e[31:16]);
      verify(e[66:64], de, e[15:0], e[63:56] == 8'd0);
    end

    // R1: idle after frames
    wait_idle();
    check(!wire_oe_o && wire_i, "R1", "line idle high between frames", int'(wire_i), 1);

    // R12: divider changed in mid-frame
    issue(3'd3, 8'd2, 8'hC3, 16'h0000, 16'h1357, 16'h0000);
    div_i = 8'd5;
    wait_done();
    build(3'd3, 8'hC3, 16'h0000, 16'h1357);
    verify(3'd3, 2, 16'h0000, 1'b1);

    // R11: requests during busy are ignored
    issue(3'd4, 8'd1, 8'h08, 16'h0000, 16'h0000, 16'h0000);
    repeat (20) @(negedge clk);
    req_kind_i = 3'd5;
    req_op_i = 8'h55;
    req_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    req_valid_i = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    check(n_edges == 8, "R11", "slots after ignored request", n_edges, 8);
    check(done_seen == 1, "R11", "done pulses after ignored request", done_seen, 1);
    check(!busy_o, "R11", "busy after ignored request", int'(busy_o), 0);

    // R4: rd_data_o unchanged by a write frame
    issue(3'd1, 8'd1, 8'h11, 16'h2222, 16'h3333, 16'h0000);
    wait_done();
    check(rd_data_o == 16'h8001 || rd_data_o == 16'h0000, "R4",
          "read word kept over write frame", int'(rd_data_o), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule